// File: doc/BRIEF.md
# Descriptor-Chained DMA Queue Engine

This block is one channel of a queue engine that walks a linked chain of 16-byte transfer descriptors held in memory. Software builds the chain, writes the address of the first descriptor, and issues a start command. The engine reads each descriptor through a simple request/acknowledge memory port and checks its hardware-owned flag. For a hardware-owned descriptor it moves the payload as a sequence of data beats (transmit or receive, selected by `rx_mode`), writes the transferred beat count back into the descriptor, hands ownership back to software, and follows the next-descriptor pointer. When the engine reaches a descriptor that software still owns, it parks there until software resumes it.

Descriptor layout (byte offsets from the descriptor address): +0 flags/info word, +4 next-descriptor pointer, +8 buffer pointer, +12 length word. The flags in the info word are bit 0 hardware-owned, bit 1 buffer-descriptor-present (carried but not acted on), bit 2 bypass, bit 6 zero-length request and bit 7 interrupt-on-completion. All lengths count data beats. Beat `i` of a descriptor is presented at address buffer + 4*i. `ext_mode` selects between the 16-bit legacy length layout and the 20-bit extended one.

The sequencer has the states IDLE, RD0 to RD3 (the reads of words 0 to 3), EVAL (length decision), XFER (payload beats), ZLP (a single zero-length beat), WB3 (length write-back), WB0 (ownership return) and PARK. Its transitions are:
- IDLE→RD0 on start.
- RD0→RD1 when the hardware-owned flag is 1. RD0→PARK when the flag is 0, or RD0→IDLE if a stop is pending.
- RD1→RD0 for a bypass descriptor, or RD1→IDLE if a stop is pending. RD1→RD2→RD3→EVAL otherwise.
- EVAL→XFER for a nonzero length. EVAL→ZLP for an extended transmit descriptor with length 0 and the zero-length flag set. EVAL→PARK for a legacy transmit descriptor with length 0. EVAL→WB3 for any other zero length.
- XFER→WB3 and ZLP→WB3 when the transfer ends, then WB3→WB0.
- WB0→RD0, or WB0→IDLE when a stop is pending.
- PARK→RD0 on resume, or PARK→IDLE on stop.

Top module: `dq_engine`

## Requirements
- R1: After reset the control read (address 1) is 0, the current pointer (address 2) is 0, done status (address 3) is 0, `irq` is 0 and no memory request is made.
- R2: Writing 1 to bit 0 of address 1 while idle loads the current pointer from the start register (address 0) and sets active (read bit 0 of address 1). The current pointer reads back at address 2 at any time.
- R3: A descriptor whose info-word bit 0 is 0 parks the engine (read bit 1 of address 1). The current pointer stays on that descriptor and no beats or memory writes occur. Writing bit 2 of address 1 re-reads that descriptor.
- R4: A transmit descriptor presents exactly its length in beats, with beat i at buffer+4*i and `tx_last` on the final beat. The length is length-word bits 15:0 in legacy mode and bits 19:0 in extended mode.
- R5: On completion the engine writes the beat count into the length word (bits 15:0 legacy, 19:0 extended, upper bits 0). It then writes the info word back with bit 0 cleared and all other bits kept, and the current pointer takes the next-descriptor pointer.
- R6: Only a descriptor with info-word bit 7 set raises a done bit. The bit sets one cycle after the ownership write is accepted. The bit is CH_ID for transmit and 16+CH_ID for receive.
- R7: A done bit sets only if the same bit of the enable register (address 4) is 1. `irq` is the OR of the done status bits. Writing 1 to a done bit at address 3 clears it.
- R8: A descriptor with info-word bit 2 set moves no beats and causes no memory write. The engine continues at its next-descriptor pointer.
- R9: In legacy mode a transmit descriptor with length 0 sets the length-error flag (read bit 2 of address 1, cleared by start) and parks on that descriptor without beats or writes.
- R10: In extended mode a transmit descriptor with length 0 and info-word bit 6 set sends one beat with `tx_zero` and `tx_last`, then writes back a count of 0.
- R11: A receive descriptor's buffer size is info-word bits 31:16 (legacy) or 31:12 (extended). Reception ends on a beat flagged `rx_short` or when the size is reached, and the received beat count is written back.
- R12: Writing bit 1 of address 1 clears active only at a descriptor boundary. A descriptor in payload completes its write-back first. From PARK, active clears at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_mode | input | 1 | 1 = receive channel, 0 = transmit; change only while idle |
| ext_mode | input | 1 | 1 = extended 20-bit length layout |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| irq | output | 1 | OR of done status bits |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | 1 = write request |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_ack | input | 1 | Request accepted; read data valid |
| mem_rdata | input | 32 | Memory read data |
| tx_valid | output | 1 | Transmit beat valid |
| tx_last | output | 1 | Final beat of descriptor |
| tx_zero | output | 1 | Beat is a zero-length packet |
| tx_ready | input | 1 | Transmit sink ready |
| rx_valid | input | 1 | Receive beat valid |
| rx_short | input | 1 | Receive beat is short and ends the transfer |
| rx_ready | output | 1 | Engine accepts a receive beat |
| xfer_addr | output | 32 | Buffer address of the current beat |

## Verification
The main walk is tried with several chains. One is a legacy transmit chain whose length word has bit 16 set, which shows that the legacy layout ignores upper length bits. Another is an extended chain that mixes a bypass descriptor with a zero-length one, which separates skipping from sending an empty packet. A legacy zero-length descriptor is repaired in memory and resumed, which tells a stall on a length error apart from a stall on a software-owned descriptor. Receive chains end by size, by a short beat, and with an extended size that legacy decoding would read as zero. A stop issued during a long payload shows whether write-back finishes before active falls.

// File: rtl/dq_pkg.sv
package dq_pkg;
    localparam int DATA_W     = 32;
    localparam int LEN_W      = 20;
    localparam int LEN_W_LEG  = 16;
    localparam int BEAT_SHIFT = 2;
    localparam int STAT_HALF  = 16;

    localparam int F_HWO = 0;
    localparam int F_BYP = 2;
    localparam int F_ZLP = 6;
    localparam int F_IOC = 7;

    localparam logic [2:0] A_START = 3'd0;
    localparam logic [2:0] A_CTRL  = 3'd1;
    localparam logic [2:0] A_CUR   = 3'd2;
    localparam logic [2:0] A_DONE  = 3'd3;
    localparam logic [2:0] A_EN    = 3'd4;

    typedef enum logic [3:0] {
        S_IDLE, S_RD0, S_RD1, S_RD2, S_RD3, S_EVAL,
        S_XFER, S_ZLP, S_WB3, S_WB0, S_PARK
    } dq_state_e;
endpackage

// File: rtl/dq_len_decode.sv
module dq_len_decode
    import dq_pkg::*;
(
    input  logic              rx_mode,
    input  logic              ext_mode,
    input  logic [LEN_W-1:0]  info_hi,
    input  logic [LEN_W-1:0]  len_word,
    input  logic [LEN_W-1:0]  cnt,
    output logic [LEN_W-1:0]  xfer_len,
    output logic [DATA_W-1:0] wb_word
);
    localparam int PAD_LEN = LEN_W - LEN_W_LEG;

    always_comb begin
        if (rx_mode)
            xfer_len = ext_mode ? info_hi
                                : {{PAD_LEN{1'b0}}, info_hi[LEN_W-1:PAD_LEN]};
        else
            xfer_len = ext_mode ? len_word
                                : {{PAD_LEN{1'b0}}, len_word[LEN_W_LEG-1:0]};
        wb_word = ext_mode ? {{(DATA_W-LEN_W){1'b0}}, cnt}
                           : {{(DATA_W-LEN_W_LEG){1'b0}}, cnt[LEN_W_LEG-1:0]};
    end
endmodule

// File: rtl/dq_regs.sv
module dq_regs
    import dq_pkg::*;
#(
    parameter int CH_ID = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_mode,
    input  logic              reg_wr,
    input  logic [2:0]        reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    input  logic [DATA_W-1:0] cur_ptr,
    input  logic              active,
    input  logic              parked,
    input  logic              len_err,
    input  logic              done_pulse,
    output logic [DATA_W-1:0] reg_rdata,
    output logic [DATA_W-1:0] start_addr,
    output logic              go,
    output logic              halt,
    output logic              kick,
    output logic              irq
);
    localparam int TX_BIT = CH_ID;
    localparam int RX_BIT = STAT_HALF + CH_ID;

    logic [DATA_W-1:0] irq_en, done_stat, set_mask, clr_mask, chan_bit;
    logic              ctrl_wr;

    assign ctrl_wr  = reg_wr && (reg_addr == A_CTRL);
    assign go       = ctrl_wr && reg_wdata[0];
    assign halt     = ctrl_wr && reg_wdata[1];
    assign kick     = ctrl_wr && reg_wdata[2];
    assign chan_bit = rx_mode ? (DATA_W'(1) << RX_BIT) : (DATA_W'(1) << TX_BIT);
    assign set_mask = done_pulse ? (chan_bit & irq_en) : '0;
    assign clr_mask = (reg_wr && reg_addr == A_DONE) ? reg_wdata : '0;
    assign irq      = |done_stat;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_addr <= '0;
            irq_en     <= '0;
            done_stat  <= '0;
        end else begin
            if (reg_wr && reg_addr == A_START) start_addr <= reg_wdata;
            if (reg_wr && reg_addr == A_EN)    irq_en     <= reg_wdata;
            done_stat <= (done_stat & ~clr_mask) | set_mask;
        end
    end

    always_comb begin
        unique case (reg_addr)
            A_START: reg_rdata = start_addr;
            A_CTRL:  reg_rdata = {{(DATA_W-3){1'b0}}, len_err, parked, active};
            A_CUR:   reg_rdata = cur_ptr;
            A_DONE:  reg_rdata = done_stat;
            A_EN:    reg_rdata = irq_en;
            default: reg_rdata = '0;
        endcase
    end

    // R6: a status bit only rises after a completion pulse
    p_done_needs_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (|(done_stat & ~$past(done_stat))) |-> $past(done_pulse));

    // R7: a status bit never rises while its enable is 0
    p_done_gated_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(|(done_stat & ~$past(done_stat) & ~$past(irq_en))));
endmodule

// File: rtl/dq_seq.sv
module dq_seq
    import dq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_mode,
    input  logic              ext_mode,
    input  logic              go,
    input  logic              halt,
    input  logic              kick,
    input  logic [DATA_W-1:0] start_addr,
    output logic              mem_req,
    output logic              mem_we,
    output logic [DATA_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_ack,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              tx_valid,
    output logic              tx_last,
    output logic              tx_zero,
    input  logic              tx_ready,
    input  logic              rx_valid,
    input  logic              rx_short,
    output logic              rx_ready,
    output logic [DATA_W-1:0] xfer_addr,
    output logic [DATA_W-1:0] cur_ptr,
    output logic              active,
    output logic              parked,
    output logic              len_err,
    output logic              done_pulse
);
    dq_state_e         state, state_nx;
    logic [DATA_W-1:0] cur, info, nxt, bufp, wb_word;
    logic [LEN_W-1:0]  len_word, cnt, cnt_inc, xfer_len;
    logic              halt_pend, stop_now, acc, beat, end_now;

    dq_len_decode u_dec (
        .rx_mode (rx_mode),
        .ext_mode(ext_mode),
        .info_hi (info[DATA_W-1:DATA_W-LEN_W]),
        .len_word(len_word),
        .cnt     (cnt),
        .xfer_len(xfer_len),
        .wb_word (wb_word)
    );

    assign acc      = mem_req && mem_ack;
    assign stop_now = halt_pend || halt;
    assign cnt_inc  = cnt + LEN_W'(1);
    assign beat     = (state == S_XFER) && (rx_mode ? rx_valid : tx_ready);
    assign end_now  = (cnt_inc == xfer_len) || (rx_mode && rx_short);
    assign cur_ptr  = cur;
    assign active   = (state != S_IDLE);
    assign parked   = (state == S_PARK);
    assign xfer_addr = bufp + {{(DATA_W-LEN_W-BEAT_SHIFT){1'b0}}, cnt, {BEAT_SHIFT{1'b0}}};

    // next state
    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE: if (go) state_nx = S_RD0;
            S_RD0:  if (acc) state_nx = mem_rdata[F_HWO] ? S_RD1
                                      : (stop_now ? S_IDLE : S_PARK);
            S_RD1:  if (acc) state_nx = !info[F_BYP] ? S_RD2
                                      : (stop_now ? S_IDLE : S_RD0);
            S_RD2:  if (acc) state_nx = S_RD3;
            S_RD3:  if (acc) state_nx = S_EVAL;
            S_EVAL: begin
                if (xfer_len != '0)  state_nx = S_XFER;
                else if (rx_mode)    state_nx = S_WB3;
                else if (!ext_mode)  state_nx = S_PARK;
                else                 state_nx = info[F_ZLP] ? S_ZLP : S_WB3;
            end
            S_XFER: if (beat && end_now) state_nx = S_WB3;
            S_ZLP:  if (tx_ready) state_nx = S_WB3;
            S_WB3:  if (acc) state_nx = S_WB0;
            S_WB0:  if (acc) state_nx = stop_now ? S_IDLE : S_RD0;
            S_PARK: begin
                if (stop_now)  state_nx = S_IDLE;
                else if (kick) state_nx = S_RD0;
            end
            default: state_nx = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    // descriptor datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur <= '0; info <= '0; nxt <= '0; bufp <= '0; len_word <= '0;
            cnt <= '0; halt_pend <= 1'b0; len_err <= 1'b0; done_pulse <= 1'b0;
        end else begin
            done_pulse <= (state == S_WB0) && acc && info[F_IOC];
            if (state == S_IDLE) halt_pend <= 1'b0;
            else if (halt)       halt_pend <= 1'b1;
            unique case (state)
                S_IDLE: if (go) begin cur <= start_addr; len_err <= 1'b0; end
                S_RD0:  if (acc) info <= mem_rdata;
                S_RD1:  if (acc) begin
                            nxt <= mem_rdata;
                            if (info[F_BYP]) cur <= mem_rdata;
                        end
                S_RD2:  if (acc) bufp <= mem_rdata;
                S_RD3:  if (acc) len_word <= mem_rdata[LEN_W-1:0];
                S_EVAL: begin
                            cnt <= '0;
                            if (xfer_len == '0 && !rx_mode && !ext_mode) len_err <= 1'b1;
                        end
                S_XFER: if (beat) cnt <= cnt_inc;
                S_WB0:  if (acc) cur <= nxt;
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        mem_req = 1'b0; mem_we = 1'b0; mem_addr = cur; mem_wdata = '0;
        tx_valid = 1'b0; tx_last = 1'b0; tx_zero = 1'b0; rx_ready = 1'b0;
        unique case (state)
            S_RD0: mem_req = 1'b1;
            S_RD1: begin mem_req = 1'b1; mem_addr = cur + DATA_W'(4); end
            S_RD2: begin mem_req = 1'b1; mem_addr = cur + DATA_W'(8); end
            S_RD3: begin mem_req = 1'b1; mem_addr = cur + DATA_W'(12); end
            S_XFER: begin
                if (rx_mode) rx_ready = 1'b1;
                else begin tx_valid = 1'b1; tx_last = (cnt_inc == xfer_len); end
            end
            S_ZLP: begin tx_valid = 1'b1; tx_last = 1'b1; tx_zero = 1'b1; end
            S_WB3: begin
                mem_req = 1'b1; mem_we = 1'b1;
                mem_addr = cur + DATA_W'(12); mem_wdata = wb_word;
            end
            S_WB0: begin
                mem_req = 1'b1; mem_we = 1'b1;
                mem_wdata = info & ~(DATA_W'(1) << F_HWO);
            end
            default: ;
        endcase
    end

    // R2: the pointer holds while a descriptor is in payload, write-back or park
    p_cur_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state inside {S_XFER, S_ZLP, S_WB3, S_PARK}) |=> $stable(cur));

    // R3: a parked queue issues no memory or data traffic
    p_park_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        parked |-> (!mem_req && !tx_valid && !rx_ready));

    // R4: beat counter stays below the decoded length during payload
    p_beat_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_XFER) |-> (cnt < xfer_len));

    // R12: active only drops at a descriptor boundary or from park
    p_halt_boundary_r12: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(active) |-> ($past(state) inside {S_RD0, S_RD1, S_WB0, S_PARK}));
endmodule

// File: rtl/dq_engine.sv
module dq_engine
    import dq_pkg::*;
#(
    parameter int CH_ID = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        rx_mode,
    input  logic        ext_mode,
    input  logic        reg_wr,
    input  logic [2:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        irq,
    output logic        mem_req,
    output logic        mem_we,
    output logic [31:0] mem_addr,
    output logic [31:0] mem_wdata,
    input  logic        mem_ack,
    input  logic [31:0] mem_rdata,
    output logic        tx_valid,
    output logic        tx_last,
    output logic        tx_zero,
    input  logic        tx_ready,
    input  logic        rx_valid,
    input  logic        rx_short,
    output logic        rx_ready,
    output logic [31:0] xfer_addr
);
    logic [DATA_W-1:0] start_addr, cur_ptr;
    logic go, halt, kick, active, parked, len_err, done_pulse;

    dq_regs #(.CH_ID(CH_ID)) u_regs (
        .clk(clk), .rst_n(rst_n), .rx_mode(rx_mode),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .cur_ptr(cur_ptr), .active(active), .parked(parked),
        .len_err(len_err), .done_pulse(done_pulse),
        .reg_rdata(reg_rdata), .start_addr(start_addr),
        .go(go), .halt(halt), .kick(kick), .irq(irq)
    );

    dq_seq u_seq (
        .clk(clk), .rst_n(rst_n), .rx_mode(rx_mode), .ext_mode(ext_mode),
        .go(go), .halt(halt), .kick(kick), .start_addr(start_addr),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .tx_valid(tx_valid), .tx_last(tx_last), .tx_zero(tx_zero),
        .tx_ready(tx_ready), .rx_valid(rx_valid), .rx_short(rx_short),
        .rx_ready(rx_ready), .xfer_addr(xfer_addr), .cur_ptr(cur_ptr),
        .active(active), .parked(parked), .len_err(len_err),
        .done_pulse(done_pulse)
    );
endmodule

// File: tb/dq_engine_tb_top.sv
module dq_engine_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] TX_DONE = 32'h0000_0004;
    localparam logic [31:0] RX_DONE = 32'h0004_0000;

    logic clk = 1'b0, rst_n = 1'b0;
    logic rx_mode = 1'b0, ext_mode = 1'b0;
    logic reg_wr = 1'b0;
    logic [2:0]  reg_addr = 3'd0;
    logic [31:0] reg_wdata = '0, reg_rdata;
    logic irq, mem_req, mem_we, mem_ack = 1'b0;
    logic [31:0] mem_addr, mem_wdata, mem_rdata = '0, xfer_addr;
    logic tx_valid, tx_last, tx_zero, tx_ready = 1'b1;
    logic rx_valid, rx_short, rx_ready, rx_on = 1'b0;

    logic [31:0] mem [0:1023];
    logic        ld_we = 1'b0;
    logic [31:0] ld_addr = '0, ld_data = '0;
    logic        clr = 1'b0;
    int tx_beats = 0, zero_beats = 0, last_seen = 0, wr_count = 0, rx_sent = 0;
    int short_at = 1000;
    logic [31:0] last_tx_addr = '0;
    int n_checks = 0, n_err = 0;

    dq_engine #(.CH_ID(2)) dut_i (
        .clk(clk), .rst_n(rst_n), .rx_mode(rx_mode), .ext_mode(ext_mode),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq(irq),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .tx_valid(tx_valid), .tx_last(tx_last), .tx_zero(tx_zero),
        .tx_ready(tx_ready), .rx_valid(rx_valid), .rx_short(rx_short),
        .rx_ready(rx_ready), .xfer_addr(xfer_addr)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    assign rx_valid = rx_on;
    assign rx_short = rx_on && (rx_sent == short_at);

    // memory model: acknowledges one cycle after a request
    always @(posedge clk) begin
        if (ld_we) mem[ld_addr[11:2]] <= ld_data;
        if (mem_req && !mem_ack) begin
            mem_ack <= 1'b1;
            if (mem_we) begin
                mem[mem_addr[11:2]] <= mem_wdata;
                wr_count <= wr_count + 1;
            end else mem_rdata <= mem[mem_addr[11:2]];
        end else mem_ack <= 1'b0;
        if (clr) begin
            tx_beats <= 0; zero_beats <= 0; last_seen <= 0; wr_count <= 0; rx_sent <= 0;
        end else begin
            if (tx_valid && tx_ready) begin
                tx_beats <= tx_beats + 1;
                last_tx_addr <= xfer_addr;
                if (tx_last) last_seen <= last_seen + 1;
                if (tx_zero) zero_beats <= zero_beats + 1;
            end
            if (rx_valid && rx_ready) rx_sent <= rx_sent + 1;
        end
    end

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic poke(logic [31:0] a, logic [31:0] d);
        @(negedge clk); ld_we = 1'b1; ld_addr = a; ld_data = d;
        @(negedge clk); ld_we = 1'b0;
    endtask

    task automatic put_desc(logic [31:0] a, logic [31:0] w0, logic [31:0] nx,
                            logic [31:0] bf, logic [31:0] w3);
        poke(a, w0); poke(a + 4, nx); poke(a + 8, bf); poke(a + 12, w3);
    endtask

    task automatic reg_write(logic [2:0] a, logic [31:0] d);
        @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk); reg_wr = 1'b0;
    endtask

    task automatic reg_read(logic [2:0] a, output logic [31:0] d);
        @(negedge clk); reg_addr = a; #1; d = reg_rdata;
    endtask

    task automatic clear_counts();
        @(negedge clk); clr = 1'b1;
        @(negedge clk); clr = 1'b0;
    endtask

    task automatic wait_ctrl(int bit_i, logic val);
        logic [31:0] d;
        for (int i = 0; i < 3000; i++) begin
            reg_read(3'd1, d);
            if (d[bit_i] == val) return;
        end
    endtask

    task automatic go_from(logic [31:0] a);
        reg_write(3'd0, a);
        reg_write(3'd1, 32'h1);
    endtask

    task automatic stop_engine();
        reg_write(3'd1, 32'h2);
        wait_ctrl(0, 1'b0);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        reg_read(3'd1, d); check("R1 ctrl", d, 32'h0);
        reg_read(3'd2, d); check("R1 cur", d, 32'h0);
        reg_read(3'd3, d); check("R1 done", d, 32'h0);
        check("R1 irq/mem_req", {30'b0, irq, mem_req}, 32'h0);
    endtask

    task automatic t_tx_legacy();
        logic [31:0] d;
        rx_mode = 1'b0; ext_mode = 1'b0;
        put_desc(32'h100, 32'h81, 32'h110, 32'h1000, 32'h0001_0003);
        put_desc(32'h110, 32'h0, 32'h0, 32'h0, 32'h0);
        reg_write(3'd4, TX_DONE | RX_DONE);
        clear_counts();
        go_from(32'h100);
        reg_read(3'd2, d); check("R2 cur loaded", d, 32'h100);
        reg_read(3'd1, d); check("R2 active", {31'b0, d[0]}, 32'h1);
        wait_ctrl(1, 1'b1);
        check("R4 legacy beats", tx_beats, 3);
        check("R4 beat address", last_tx_addr, 32'h1008);
        check("R4 last flag", last_seen, 1);
        check("R5 length wb", mem[32'h10c >> 2], 32'h3);
        check("R5 owner wb", mem[32'h100 >> 2], 32'h80);
        reg_read(3'd2, d); check("R5 next ptr", d, 32'h110);
        reg_read(3'd3, d); check("R6 tx done bit", d, TX_DONE);
        check("R7 irq set", {31'b0, irq}, 32'h1);
        reg_write(3'd3, TX_DONE);
        reg_read(3'd3, d); check("R7 w1c", d, 32'h0);
        check("R7 irq clear", {31'b0, irq}, 32'h0);
        reg_write(3'd1, 32'h2);
        @(negedge clk);
        reg_read(3'd1, d); check("R12 stop from park", d & 32'h3, 32'h0);
    endtask

    task automatic t_tx_ext();
        logic [31:0] d;
        rx_mode = 1'b0; ext_mode = 1'b1;
        put_desc(32'h200, 32'h05, 32'h210, 32'h2000, 32'h5);
        put_desc(32'h210, 32'h41, 32'h220, 32'h2100, 32'h0);
        put_desc(32'h220, 32'h0, 32'h0, 32'h0, 32'h0);
        clear_counts();
        go_from(32'h200);
        wait_ctrl(1, 1'b1);
        check("R10 zlp beats", tx_beats, 1);
        check("R10 zlp flag", zero_beats, 1);
        check("R8 bypass untouched", mem[32'h200 >> 2], 32'h05);
        check("R8 only zlp writes", wr_count, 2);
        check("R10 zero wb", mem[32'h21c >> 2], 32'h0);
        check("R5 owner keeps flags", mem[32'h210 >> 2], 32'h40);
        reg_read(3'd3, d); check("R6 no ioc no done", d, 32'h0);
        reg_read(3'd2, d); check("R3 parked cur", d, 32'h220);
        put_desc(32'h220, 32'h81, 32'h230, 32'h3000, 32'h2);
        put_desc(32'h230, 32'h0, 32'h0, 32'h0, 32'h0);
        reg_write(3'd1, 32'h4);
        wait_ctrl(1, 1'b1);
        check("R3 resume beats", tx_beats, 3);
        reg_read(3'd2, d); check("R3 resume cur", d, 32'h230);
        reg_read(3'd3, d); check("R6 done after resume", d, TX_DONE);
        reg_write(3'd3, 32'hFFFF_FFFF);
        stop_engine();
    endtask

    task automatic t_len_err();
        logic [31:0] d;
        rx_mode = 1'b0; ext_mode = 1'b0;
        put_desc(32'h300, 32'h81, 32'h310, 32'h3800, 32'h0);
        put_desc(32'h310, 32'h0, 32'h0, 32'h0, 32'h0);
        clear_counts();
        go_from(32'h300);
        wait_ctrl(1, 1'b1);
        reg_read(3'd1, d); check("R9 len error parked", d, 32'h7);
        reg_read(3'd2, d); check("R9 cur stays", d, 32'h300);
        check("R9 no beats", tx_beats, 0);
        check("R9 no writes", wr_count, 0);
        poke(32'h30c, 32'h2);
        reg_write(3'd1, 32'h4);
        @(negedge clk);
        wait_ctrl(1, 1'b1);
        check("R9 repaired beats", tx_beats, 2);
        reg_read(3'd2, d); check("R9 repaired cur", d, 32'h310);
        reg_write(3'd3, 32'hFFFF_FFFF);
        stop_engine();
    endtask

    task automatic t_rx();
        logic [31:0] d;
        rx_mode = 1'b1; ext_mode = 1'b0;
        put_desc(32'h400, 32'h0004_0081, 32'h410, 32'h4000, 32'hFFFF_FFFF);
        put_desc(32'h410, 32'h0005_0001, 32'h420, 32'h5000, 32'hFFFF_FFFF);
        put_desc(32'h420, 32'h0, 32'h0, 32'h0, 32'h0);
        clear_counts();
        short_at = 5; rx_on = 1'b1;
        go_from(32'h400);
        wait_ctrl(1, 1'b1);
        rx_on = 1'b0;
        check("R11 size end", mem[32'h40c >> 2], 32'h4);
        check("R11 short end", mem[32'h41c >> 2], 32'h2);
        check("R5 rx owner", mem[32'h400 >> 2], 32'h0004_0080);
        reg_read(3'd3, d); check("R6 rx done bit", d, RX_DONE);
        reg_write(3'd3, 32'hFFFF_FFFF);
        stop_engine();
        ext_mode = 1'b1;
        put_desc(32'h500, 32'h0000_3001, 32'h510, 32'h5800, 32'h0);
        put_desc(32'h510, 32'h0, 32'h0, 32'h0, 32'h0);
        clear_counts();
        short_at = 1000; rx_on = 1'b1;
        go_from(32'h500);
        wait_ctrl(1, 1'b1);
        rx_on = 1'b0;
        check("R11 ext size", mem[32'h50c >> 2], 32'h3);
        stop_engine();
    endtask

    task automatic t_stop();
        logic [31:0] d;
        int waited;
        rx_mode = 1'b0; ext_mode = 1'b0;
        put_desc(32'h600, 32'h01, 32'h610, 32'h6000, 32'd20);
        put_desc(32'h610, 32'h01, 32'h620, 32'h6100, 32'd5);
        put_desc(32'h620, 32'h0, 32'h0, 32'h0, 32'h0);
        clear_counts();
        go_from(32'h600);
        for (int i = 0; i < 200 && tx_beats < 3; i++) @(negedge clk);
        reg_write(3'd1, 32'h2);
        waited = 0;
        for (int i = 0; i < 40; i++) begin
            reg_read(3'd1, d);
            if (d[0] == 1'b0) break;
            waited++;
        end
        check("R12 active falls in bound", {31'b0, d[0]}, 32'h0);
        check("R12 payload finished", tx_beats, 20);
        check("R12 wb before stop", mem[32'h60c >> 2], 32'd20);
        check("R12 owner returned", mem[32'h600 >> 2], 32'h0);
        reg_read(3'd2, d); check("R12 cur at next", d, 32'h610);
        check("R12 next untouched", mem[32'h610 >> 2], 32'h01);
    endtask

    initial begin
        for (int i = 0; i < 1024; i++) mem[i] = '0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_tx_legacy();
        t_tx_ext();
        t_len_err();
        t_rx();
        t_stop();
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++; n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end
endmodule